// File: doc/BRIEF.md
# Serial Command Receiver for an Eight-Channel Converter Register Bank

This block accepts 16-bit command words on a three-wire serial link: a serial clock, an active-low frame line and a data line. It decodes each completed word into writes on a register bank. The bank holds eight 12-bit channel values, two 12-bit control words and a one-cycle update pulse. All three serial lines are asynchronous to the system clock. Each passes through a synchronizer chain before any edge is detected, so the serial clock must be well below the system clock rate.

A static mode input selects the framing discipline. In controller framing the frame line must stay low for the whole word. The word commits only when the frame line rises after all sixteen bits have arrived. In short-pulse framing a brief low pulse on the frame line opens a word, and the word commits on its own once sixteen bits are in. That pulse counts only if a falling serial clock edge was seen while the receiver was idle. The mode is sampled when a word starts and must not change while a word is in flight.

Top module: `sdac_cmd_if`

## Requirements
- R1: Each word is sent most significant bit first. One bit is taken from the data line on each synchronized falling edge of the serial clock. Bits 15..12 form the address and bits 11..0 form the data field.
- R2: With modeSel = 1, a rising frame line seen before the sixteenth falling clock edge discards the word. No register changes and no update pulse follows. A rise seen in the same synchronized cycle as the sixteenth falling edge also aborts.
- R3: With modeSel = 1, a complete word commits only on the next rising edge of the frame line.
- R4: With modeSel = 0, a falling frame line opens a word. The frame line may rise at any point during the word, or stay low. The word commits automatically after the sixteenth falling clock edge.
- R5: With modeSel = 0, a falling frame line is ignored unless a falling serial clock edge was seen in an earlier cycle while the receiver was idle.
- R6: Address codes 0 through 7 write the data field to channel 0 through 7 respectively.
- R7: Address code 8 writes control word 0, and address code 9 writes control word 1.
- R8: Address code 10 loads the data field into all eight channels at once.
- R9: Address code 11 is accepted but changes no register and produces no update pulse.
- R10: Address codes 12, 13, 14 and 15 write the data field into channel pairs 0/1, 2/3, 4/5 and 6/7 respectively, in one commit.
- R11: Every commit to an address other than 11 produces exactly one update pulse that lasts one clock cycle.
- R12: A synchronous active-high reset clears all channels, both control words and the update pulse. It also returns the receiver to idle with no arming pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| serClk | input | 1 | Serial clock, asynchronous; data is taken on its falling edge |
| frameN | input | 1 | Active-low frame line, asynchronous |
| serData | input | 1 | Serial data line, asynchronous |
| modeSel | input | 1 | 1 = controller framing, 0 = short-pulse framing |
| chanVal | output | 96 | Eight 12-bit channel values; channel k occupies bits 12k+11..12k |
| ctrlReg0 | output | 12 | Control word 0 |
| ctrlReg1 | output | 12 | Control word 1 |
| updatePulse | output | 1 | One-cycle pulse after each effective commit |

## Verification
In controller framing, two events can land in the same synchronized cycle: the sixteenth falling clock edge, which would complete the word, and the rising frame line, which would abort it. A directed case drives both transitions at the same instant. The bench expects the abort to win: the channels stay unchanged and no update pulse appears. Random words in both modes, with random early aborts, are compared against a bench model of the address map after every word.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  localparam int ADDR_W = 4;

  localparam logic [ADDR_W-1:0] CODE_CTRL0  = 4'h8;
  localparam logic [ADDR_W-1:0] CODE_CTRL1  = 4'h9;
  localparam logic [ADDR_W-1:0] CODE_PRESET = 4'hA;
  localparam logic [ADDR_W-1:0] CODE_RSV    = 4'hB;

  typedef struct packed {
    logic shift;
    logic bitVal;
    logic commit;
  } seqStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_HOLD,
    ST_FIRE
  } frameState_t;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [STAGES-1:0][WIDTH-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= asyncIn;
      for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
    end
  end

  assign syncOut = stg[STAGES-1];
endmodule

// File: rtl/sdac_frame_ctrl.sv
module sdac_frame_ctrl
  import sdac_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       serClk,
  input  logic       frameN,
  input  logic       serData,
  input  logic       modeSel,
  output seqStrobe_t strb
);
  localparam int CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

  logic [2:0] syncVec;
  logic sclkS, fsS, dinS;
  logic sclkQ, fsQ;
  logic sclkFall, fsFall, fsRise;
  frameState_t state;
  logic [CNT_W-1:0] bitCnt;
  logic armed;
  logic frameMode;

  sdac_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .asyncIn ({serData, frameN, serClk}),
    .syncOut (syncVec)
  );

  assign sclkS = syncVec[0];
  assign fsS   = syncVec[1];
  assign dinS  = syncVec[2];

  assign sclkFall = sclkQ & ~sclkS;
  assign fsFall   = fsQ & ~fsS;
  assign fsRise   = ~fsQ & fsS;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bitCnt    <= '0;
      armed     <= 1'b0;
      frameMode <= 1'b0;
      strb      <= '0;
      sclkQ     <= 1'b0;
      fsQ       <= 1'b1;
    end else begin
      sclkQ <= sclkS;
      fsQ   <= fsS;
      strb  <= '0;
      case (state)
        ST_IDLE: begin
          if (sclkFall) armed <= 1'b1;
          if (fsFall && (modeSel || armed)) begin
            state     <= ST_SHIFT;
            bitCnt    <= '0;
            armed     <= 1'b0;
            frameMode <= modeSel;
          end
        end
        ST_SHIFT: begin
          if (frameMode && fsRise) begin
            state <= ST_IDLE;
          end else if (sclkFall) begin
            strb.shift  <= 1'b1;
            strb.bitVal <= dinS;
            bitCnt      <= bitCnt + 1'b1;
            if (bitCnt == LAST_BIT) state <= frameMode ? ST_HOLD : ST_FIRE;
          end
        end
        ST_HOLD: begin
          if (fsRise) begin
            strb.commit <= 1'b1;
            state       <= ST_IDLE;
          end
        end
        ST_FIRE: begin
          strb.commit <= 1'b1;
          state       <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: an early rise in controller framing returns to idle without a commit
  a_r2_abort_no_commit: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SHIFT && frameMode && fsRise) |=> (state == ST_IDLE && !strb.commit));

  // R3: a complete controller word waits for the frame line to rise
  a_r3_hold_waits: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HOLD && !fsRise) |=> (state == ST_HOLD && !strb.commit));

  // R4: short-pulse framing commits right after the last bit
  a_r4_auto_commit: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FIRE) |=> (strb.commit && state == ST_IDLE));

  // R5: an unarmed falling frame line in short-pulse framing is ignored
  a_r5_unarmed_ignored: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && fsFall && !modeSel && !armed) |=> (state == ST_IDLE));

  // R1: the bit counter never passes the word length
  a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
    bitCnt <= CNT_W'(WORD_W));
endmodule

// File: rtl/sdac_reg_bank.sv
module sdac_reg_bank
  import sdac_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  seqStrobe_t               strb,
  output logic [NUM_CH*DATA_W-1:0] chanFlat,
  output logic [DATA_W-1:0]        ctrl0,
  output logic [DATA_W-1:0]        ctrl1,
  output logic                     updatePulse
);
  localparam int WORD_W = ADDR_W + DATA_W;

  logic [WORD_W-1:0] shiftReg;
  logic [ADDR_W-1:0] addrF;
  logic [DATA_W-1:0] dataF;
  logic isSingle, isPair, isPreset;

  assign addrF    = shiftReg[WORD_W-1 -: ADDR_W];
  assign dataF    = shiftReg[DATA_W-1:0];
  assign isSingle = (addrF[3] == 1'b0);
  assign isPair   = (addrF[3:2] == 2'b11);
  assign isPreset = (addrF == CODE_PRESET);

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
    end else if (strb.shift) begin
      shiftReg <= {shiftReg[WORD_W-2:0], strb.bitVal};
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic wrEn;
    logic [DATA_W-1:0] val;

    assign wrEn = strb.commit &&
                  ((isSingle && addrF[2:0] == 3'(ch)) ||
                   (isPair && addrF[1:0] == 2'(ch / 2)) ||
                   isPreset);

    always_ff @(posedge clk) begin
      if (rst) val <= '0;
      else if (wrEn) val <= dataF;
    end

    assign chanFlat[ch*DATA_W +: DATA_W] = val;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl0       <= '0;
      ctrl1       <= '0;
      updatePulse <= 1'b0;
    end else begin
      updatePulse <= strb.commit && (addrF != CODE_RSV);
      if (strb.commit && addrF == CODE_CTRL0) ctrl0 <= dataF;
      if (strb.commit && addrF == CODE_CTRL1) ctrl1 <= dataF;
    end
  end

  // R11: the update pulse never lasts longer than one cycle
  a_r11_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    updatePulse |=> !updatePulse);

  // R9: the reserved code leaves every register alone
  a_r9_reserved_quiet: assert property (@(posedge clk) disable iff (rst)
    (strb.commit && addrF == CODE_RSV) |=>
      (!updatePulse && $stable(chanFlat) && $stable(ctrl0) && $stable(ctrl1)));

  // R8: preset fills every channel with the data field
  a_r8_preset_all: assert property (@(posedge clk) disable iff (rst)
    (strb.commit && isPreset) |=> (chanFlat == {NUM_CH{$past(dataF)}}));

  // R7: a control write leaves the channels unchanged
  a_r7_ctrl_no_chan: assert property (@(posedge clk) disable iff (rst)
    (strb.commit && (addrF == CODE_CTRL0 || addrF == CODE_CTRL1)) |=> $stable(chanFlat));

  // R12: reset clears the bank
  a_r12_reset_clear: assert property (@(posedge clk)
    rst |=> (chanFlat == '0 && ctrl0 == '0 && ctrl1 == '0 && !updatePulse));
endmodule

// File: rtl/sdac_cmd_if.sv
module sdac_cmd_if
  import sdac_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int NUM_CH = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     serClk,
  input  logic                     frameN,
  input  logic                     serData,
  input  logic                     modeSel,
  output logic [NUM_CH*DATA_W-1:0] chanVal,
  output logic [DATA_W-1:0]        ctrlReg0,
  output logic [DATA_W-1:0]        ctrlReg1,
  output logic                     updatePulse
);
  localparam int WORD_W = ADDR_W + DATA_W;

  seqStrobe_t strb;

  sdac_frame_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .serClk  (serClk),
    .frameN  (frameN),
    .serData (serData),
    .modeSel (modeSel),
    .strb    (strb)
  );

  sdac_reg_bank #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_bank (
    .clk         (clk),
    .rst         (rst),
    .strb        (strb),
    .chanFlat    (chanVal),
    .ctrl0       (ctrlReg0),
    .ctrl1       (ctrlReg1),
    .updatePulse (updatePulse)
  );
endmodule

// File: tb/test_sdac_cmd_if.sv
module test_sdac_cmd_if;
  localparam int DW = 12;
  localparam int NCH = 8;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclk = 1'b0;
  logic fsN = 1'b1;
  logic din = 1'b0;
  logic mode = 1'b1;
  logic [NCH*DW-1:0] chanVal;
  logic [DW-1:0] ctrlReg0, ctrlReg1;
  logic upd;

  int checks = 0;
  int fails = 0;
  int pulseCnt = 0;
  bit done = 1'b0;

  logic [DW-1:0] expChan [NCH];
  logic [DW-1:0] expC0, expC1;

  sdac_cmd_if i_sdac_cmd_if (
    .clk(clk), .rst(rst), .serClk(sclk), .frameN(fsN), .serData(din),
    .modeSel(mode), .chanVal(chanVal), .ctrlReg0(ctrlReg0),
    .ctrlReg1(ctrlReg1), .updatePulse(upd)
  );

  always #2 clk = ~clk;

  always @(posedge clk) if (!rst && upd) pulseCnt++;

  task automatic waitCyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int applyModel(logic [15:0] w);
    logic [3:0] a = w[15:12];
    logic [DW-1:0] d = w[11:0];
    if (a < 4'd8) expChan[a[2:0]] = d;
    else if (a == 4'd8) expC0 = d;
    else if (a == 4'd9) expC1 = d;
    else if (a == 4'd10) begin
      for (int k = 0; k < NCH; k++) expChan[k] = d;
    end else if (a == 4'd11) return 0;
    else begin
      expChan[{a[1:0], 1'b0}] = d;
      expChan[{a[1:0], 1'b1}] = d;
    end
    return 1;
  endfunction

  task automatic checkAll(string req, int expPulses, int p0);
    for (int k = 0; k < NCH; k++)
      check(req, $sformatf("chan%0d", k), chanVal[k*DW +: DW], expChan[k]);
    check(req, "ctrl0", ctrlReg0, expC0);
    check(req, "ctrl1", ctrlReg1, expC1);
    check(req, "update pulses (R11)", pulseCnt - p0, expPulses);
  endtask

  task automatic bitOut(logic b);
    din = b; sclk = 1'b1; waitCyc(H);
    sclk = 1'b0; waitCyc(H);
  endtask

  // controller framing; abortAt = bits sent before the frame line rises
  task automatic runCtrl(string req, logic [15:0] w, int abortAt, bit together);
    int p0 = pulseCnt;
    int e = (abortAt == 16 && !together) ? applyModel(w) : 0;
    mode = 1'b1; waitCyc(H);
    fsN = 1'b0; waitCyc(H);
    for (int i = 0; i < abortAt; i++) begin
      if (together && i == 15) begin
        din = w[15-i]; sclk = 1'b1; waitCyc(H);
        sclk = 1'b0; fsN = 1'b1; waitCyc(H);
      end else begin
        bitOut(w[15-i]);
      end
    end
    fsN = 1'b1; waitCyc(20);
    checkAll(req, e, p0);
  endtask

  // short-pulse framing
  task automatic runDsp(string req, logic [15:0] w, bit arm, bit holdLow);
    int p0 = pulseCnt;
    int e = arm ? applyModel(w) : 0;
    mode = 1'b0; waitCyc(H);
    if (arm) begin
      sclk = 1'b1; waitCyc(H);
      sclk = 1'b0; waitCyc(H);
    end
    fsN = 1'b0; waitCyc(H);
    for (int i = 0; i < 16; i++) begin
      bitOut(w[15-i]);
      if (i == 0 && !holdLow) fsN = 1'b1;
    end
    fsN = 1'b1; waitCyc(20);
    checkAll(req, e, p0);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < NCH; k++) expChan[k] = '0;
    expC0 = '0; expC1 = '0;
    waitCyc(5);
    rst = 1'b0;
    waitCyc(2);
    checkAll("R12 reset state", 0, pulseCnt);
    check("R12", "updatePulse", upd, 0);

    // R6: each single channel, alternating framing modes
    for (int ch = 0; ch < NCH; ch++) begin
      logic [15:0] w = {4'(ch), 12'(12'h111 * (ch + 1))};
      if (ch % 2 == 0) runDsp("R6", w, 1'b1, 1'b0);
      else runCtrl("R6", w, 16, 1'b0);
    end
    // R1: asymmetric pattern reveals bit order
    runCtrl("R1", 16'h3801, 16, 1'b0);
    runDsp("R1", 16'h5C35, 1'b1, 1'b0);
    // R7
    runCtrl("R7", 16'h8ABC, 16, 1'b0);
    runDsp("R7", 16'h9FED, 1'b1, 1'b1);
    // R10: all four pairs
    runCtrl("R10", 16'hC0A1, 16, 1'b0);
    runDsp("R10", 16'hD0B2, 1'b1, 1'b0);
    runCtrl("R10", 16'hE0C3, 16, 1'b0);
    runDsp("R10", 16'hF0D4, 1'b1, 1'b1);
    // R9: reserved
    runCtrl("R9", 16'hBFFF, 16, 1'b0);
    runDsp("R9", 16'hB123, 1'b1, 1'b0);
    // R8: preset
    runDsp("R8", 16'hA777, 1'b1, 1'b0);
    // R2: early aborts and abort coinciding with the last edge
    runCtrl("R2", 16'h0EEE, 15, 1'b0);
    runCtrl("R2", 16'h1DDD, 5, 1'b0);
    runCtrl("R2", 16'h2CCC, 0, 1'b0);
    runCtrl("R2 coincident", 16'h3BBB, 16, 1'b1);
    // R3: complete controller word
    runCtrl("R3", 16'h7ABC, 16, 1'b0);
    // R4: early rise and held-low frame line
    runDsp("R4", 16'h6543, 1'b1, 1'b0);
    runDsp("R4", 16'h4321, 1'b1, 1'b1);
    // R5: unarmed start right after a short-pulse word
    runDsp("R5", 16'h2999, 1'b0, 1'b0);
    runDsp("R5 rearmed", 16'h2998, 1'b1, 1'b0);

    for (int n = 0; n < 48; n++) begin
      logic [15:0] w = 16'($urandom);
      if ($urandom % 2 == 1) begin
        int ab = ($urandom % 4 == 0) ? int'(1 + $urandom % 15) : 16;
        runCtrl("R11 random", w, ab, 1'b0);
      end else begin
        runDsp("R11 random", w, 1'b1, 1'($urandom % 2));
      end
    end

    rst = 1'b1; waitCyc(2);
    rst = 1'b0; waitCyc(1);
    for (int k = 0; k < NCH; k++) expChan[k] = '0;
    expC0 = '0; expC1 = '0;
    checkAll("R12 mid-run", 0, pulseCnt);
    runDsp("R12 arm cleared", 16'h1555, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule